// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets a host processor run single read or write transactions against external PHY devices on the two-wire station management bus. Software writes one command word that carries a start flag, a direction flag, a 5-bit PHY address, a 5-bit register address and 16 bits of data. The controller derives the management clock from the system clock and shifts a clause 22 frame onto a bidirectional data line, which is split into an output, an output-enable and an input. It releases the line while the PHY answers a read.

Completion is reported in three ways. The start flag clears by itself. A result flag tells whether the PHY acknowledged a read. A sticky raw event bit feeds a maskable interrupt. Software can poll the start flag or wait for the interrupt. A command written while a transaction is still running is dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the command word reads 0, mdc and mdio_oe are low, and irq is low.
- R2: A write transaction (command bit 30 = 1) sends exactly 64 bits on mdio_o, MSB first, with mdio_oe high for all of them. The bits are 32 ones, then 01, then 01, then the PHY address (bits 20:16), then the register address (bits 25:21), then 10, then the data (bits 15:0).
- R3: A read transaction (bit 30 = 0) sends the same 46-bit header with opcode 10. It then drops mdio_oe for the last 18 bit times, and the 16 bits sampled from mdio_i in the final 16 bit times, MSB first, appear in command bits 15:0 when the start flag clears.
- R4: Writing the command word (address 0) with bit 31 set starts a transaction. Bit 31 reads 1 for the whole transaction and returns to 0 when it ends.
- R5: The acknowledge flag (bit 29) reads 1 after a read only if mdio_i was low in the second turnaround bit time. It reads 0 after a write.
- R6: A write to the command word while bit 31 is 1 changes neither the stored fields nor the frame in flight.
- R7: mdc has a period of 2*MDC_HALF system clocks. While mdio_oe stays high, mdio_o changes only in the cycle mdc falls, and mdio_i is sampled when mdc rises.
- R8: Every completed read or write sets the raw event bit (address 1, bit 0). Writing 1 to that bit clears it.
- R9: Writing 1 to bit 0 at address 2 enables the interrupt, and writing 1 to bit 0 at address 3 disables it. Address 4 bit 0 reads raw AND enable, and irq equals that value.
- R10: While no transaction runs, mdc stays low and mdio_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the controller with MDC_HALF = 2, so each bit time is four system clocks. This makes a 64-bit frame short enough to run dozens of random reads and writes plus the directed corners: address fields at 0 and 31, data of all ones and all zeros, a missing turnaround acknowledge, an overwrite attempt in mid-frame, and the interrupt with its enable on and off. A behavioural PHY on the other end of the line drives the turnaround and data bits after each falling edge of mdc. The same PHY records every bit seen on a rising edge, so each frame is compared with one rebuilt in the bench.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = 46;
    localparam int TA_ACK     = 47;
    localparam int RD_FIRST   = 48;
    localparam int REG_W      = 5;
    localparam int PHY_W      = 5;
    localparam int DATA_W     = 16;
    localparam int BUS_W      = 32;

    localparam int GO_BIT     = 31;
    localparam int WR_BIT     = 30;
    localparam int ACK_BIT    = 29;
    localparam int REG_LSB    = 21;
    localparam int PHY_LSB    = 16;

    typedef enum logic [2:0] {
        RA_CMD    = 3'd0,
        RA_RAW    = 3'd1,
        RA_MSET   = 3'd2,
        RA_MCLR   = 3'd3,
        RA_MASKED = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              go;
        logic              wr;
        logic              ack;
        logic [REG_W-1:0]  regadr;
        logic [PHY_W-1:0]  phyadr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic              wr;
        logic [PHY_W-1:0]  phyadr;
        logic [REG_W-1:0]  regadr;
        logic [DATA_W-1:0] data;
    } req_t;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] data;
    } rsp_t;

    function automatic cmd_t decode_cmd(input logic [BUS_W-1:0] w);
        cmd_t c;
        c.go     = w[GO_BIT];
        c.wr     = w[WR_BIT];
        c.ack    = 1'b0;
        c.regadr = w[REG_LSB +: REG_W];
        c.phyadr = w[PHY_LSB +: PHY_W];
        c.data   = w[DATA_W-1:0];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] encode_cmd(input cmd_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[GO_BIT]            = c.go;
        w[WR_BIT]            = c.wr;
        w[ACK_BIT]           = c.ack;
        w[REG_LSB +: REG_W]  = c.regadr;
        w[PHY_LSB +: PHY_W]  = c.phyadr;
        w[DATA_W-1:0]        = c.data;
        return w;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input req_t r);
        return {32'hFFFF_FFFF,
                2'b01,
                (r.wr ? 2'b01 : 2'b10),
                r.phyadr,
                r.regadr,
                (r.wr ? 2'b10 : 2'b11),
                (r.wr ? r.data : {DATA_W{1'b1}})};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = en && (cnt == CW'(HALF - 1));
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  req_t req,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic mdio_i,
    output logic busy,
    output logic mdio_o,
    output logic mdio_oe,
    output logic done,
    output rsp_t rsp
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sh;
    logic [IDX_W-1:0]      idx;
    logic                  wr_q;
    logic                  ack_q;
    logic [DATA_W-1:0]     rd_sh;

    assign mdio_o   = sh[FRAME_BITS-1];
    assign done     = busy && fall_evt && (idx == LAST_IDX);
    assign rsp.ack  = ack_q;
    assign rsp.data = rd_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '1;
            idx     <= '0;
            wr_q    <= 1'b0;
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            ack_q   <= 1'b0;
            rd_sh   <= '0;
        end else if (start && !busy) begin
            sh      <= build_frame(req);
            idx     <= '0;
            wr_q    <= req.wr;
            busy    <= 1'b1;
            mdio_oe <= 1'b1;
            ack_q   <= 1'b0;
        end else if (busy) begin
            if (rise_evt) begin
                if (idx == IDX_W'(TA_ACK)) begin
                    ack_q <= ~mdio_i;
                end
                if (idx >= IDX_W'(RD_FIRST)) begin
                    rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
                end
            end
            if (fall_evt) begin
                if (idx == LAST_IDX) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                end else begin
                    idx     <= idx + 1'b1;
                    sh      <= {sh[FRAME_BITS-2:0], 1'b1};
                    mdio_oe <= wr_q || (idx < IDX_W'(TA_FIRST - 1));
                end
            end
        end
    end

endmodule

// File: rtl/mdio_irq_ctl.sv
module mdio_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic raw_clr,
    input  logic mask_set,
    input  logic mask_clr,
    output logic raw,
    output logic mask,
    output logic masked,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= 1'b0;
            mask <= 1'b0;
        end else begin
            if (set_evt) begin
                raw <= 1'b1;
            end else if (raw_clr) begin
                raw <= 1'b0;
            end
            if (mask_set) begin
                mask <= 1'b1;
            end else if (mask_clr) begin
                mask <= 1'b0;
            end
        end
    end

    assign masked = raw & mask;
    assign irq    = masked;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int MDC_HALF = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        irq
);
    cmd_t cmd_q;
    cmd_t cmd_in;
    req_t req;
    rsp_t rsp;
    logic cmd_accept;
    logic start;
    logic eng_busy;
    logic eng_done;
    logic rise_evt;
    logic fall_evt;
    logic irq_raw;
    logic irq_mask;
    logic irq_masked;
    logic wr_raw;
    logic wr_mset;
    logic wr_mclr;

    assign cmd_in     = decode_cmd(host_wdata);
    assign cmd_accept = host_we && (host_addr == RA_CMD) && !cmd_q.go;
    assign start      = cmd_accept && cmd_in.go;
    assign wr_raw     = host_we && (host_addr == RA_RAW)  && host_wdata[0];
    assign wr_mset    = host_we && (host_addr == RA_MSET) && host_wdata[0];
    assign wr_mclr    = host_we && (host_addr == RA_MCLR) && host_wdata[0];

    assign req.wr     = cmd_in.wr;
    assign req.phyadr = cmd_in.phyadr;
    assign req.regadr = cmd_in.regadr;
    assign req.data   = cmd_in.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_accept) begin
            cmd_q <= cmd_in;
        end else if (eng_done) begin
            cmd_q.go  <= 1'b0;
            cmd_q.ack <= !cmd_q.wr && rsp.ack;
            if (!cmd_q.wr) begin
                cmd_q.data <= rsp.data;
            end
        end
    end

    mdio_mdc_gen #(
        .HALF(MDC_HALF)
    ) u_mdc_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (eng_busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (eng_done),
        .rsp      (rsp)
    );

    mdio_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_evt  (eng_done),
        .raw_clr  (wr_raw),
        .mask_set (wr_mset),
        .mask_clr (wr_mclr),
        .raw      (irq_raw),
        .mask     (irq_mask),
        .masked   (irq_masked),
        .irq      (irq)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_CMD:    host_rdata = encode_cmd(cmd_q);
            RA_RAW:    host_rdata[0] = irq_raw;
            RA_MSET,
            RA_MCLR:   host_rdata[0] = irq_mask;
            RA_MASKED: host_rdata[0] = irq_masked;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_mgmt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       eng_done,
    input logic       irq_raw,
    input logic       irq_mask,
    input logic       irq,
    input cmd_t       cmd_q,
    input logic       host_we,
    input logic [2:0] host_addr
);
    // R10
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_q.go |-> (!mdc && !mdio_oe));

    // R7
    data_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

    // R4
    go_held_while_clocking_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> cmd_q.go);

    // R8
    raw_set_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> irq_raw);

    // R6
    busy_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.go && host_we && (host_addr == 3'd0) && !eng_done) |=> $stable(cmd_q));

    // R9
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_raw && irq_mask));

    // R9
    irq_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_raw && irq_mask) |-> irq);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .eng_done  (eng_done),
    .irq_raw   (irq_raw),
    .irq_mask  (irq_mask),
    .irq       (irq),
    .cmd_q     (cmd_q),
    .host_we   (host_we),
    .host_addr (host_addr)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;
    logic        irq;

    int          checks = 0;
    int          errors = 0;

    // behavioural PHY
    int          rise_cnt = 0;
    logic [63:0] cap_bit = '0;
    logic [63:0] cap_oe = '0;
    logic        phy_drv = 1'b1;
    logic        phy_ack_en = 1'b1;
    logic [15:0] phy_rdata = '0;
    time         last_rise = 0;
    int          period_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    mdio_mgmt_ctrl #(.MDC_HALF(HALF)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
    );

    always @(posedge mdc) begin
        if (rise_cnt > 0 && ($time - last_rise) != time'(2*HALF*CLK_PERIOD)) period_bad++;
        last_rise = $time;
        if (rise_cnt < 64) begin
            cap_bit[63-rise_cnt] = mdio_o;
            cap_oe[63-rise_cnt]  = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        #1;
        if (rise_cnt == 47) phy_drv = phy_ack_en ? 1'b0 : 1'b1;
        else if (rise_cnt >= 48 && rise_cnt < 64) phy_drv = phy_rdata[15-(rise_cnt-48)];
        else phy_drv = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [31:0] cmd_word(bit go, bit wr, bit ack, logic [4:0] r,
                                             logic [4:0] p, logic [15:0] d);
        logic [31:0] w;
        w = '0;
        w[31] = go; w[30] = wr; w[29] = ack;
        w[25:21] = r; w[20:16] = p; w[15:0] = d;
        return w;
    endfunction

    function automatic logic [63:0] ref_frame(bit wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [63:0] f;
        f = '1;
        f[31:30] = 2'b01;
        f[29:28] = wr ? 2'b01 : 2'b10;
        f[27:23] = p;
        f[22:18] = r;
        f[17:16] = 2'b10;
        f[15:0]  = d;
        return f;
    endfunction

    task automatic run_txn(input bit wr, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input bit ack_en, input logic [15:0] rd,
                           input bit try_overwrite);
        logic [31:0] v;
        logic [63:0] f;
        logic [63:0] eoe;
        int n;
        rise_cnt = 0; period_bad = 0; cap_bit = '0; cap_oe = '0;
        phy_ack_en = ack_en; phy_rdata = rd;
        bus_write(3'd0, cmd_word(1'b1, wr, 1'b0, r, p, d));
        bus_read(3'd0, v);
        chk("R4 go set while running", 64'(v[31]), 64'd1);
        if (try_overwrite) begin
            bus_write(3'd0, cmd_word(1'b1, ~wr, 1'b0, ~r, ~p, ~d));
            bus_read(3'd0, v);
            chk("R6 fields kept during busy write", 64'(v), 64'(cmd_word(1'b1, wr, 1'b0, r, p, d)));
        end
        n = 0;
        v = 32'h8000_0000;
        while (v[31] && n < 3000) begin
            bus_read(3'd0, v);
            n++;
        end
        chk("R4 go cleared at end", 64'(v[31]), 64'd0);
        chk("R7 bit count", 64'(rise_cnt), 64'd64);
        chk("R7 mdc period", 64'(period_bad), 64'd0);
        f = ref_frame(wr, p, r, d);
        if (wr) begin
            chk("R2 write frame", cap_bit, f);
            chk("R2 write oe", cap_oe, '1);
            chk("R5 ack after write", 64'(v[29]), 64'd0);
            chk("R2 data kept after write", 64'(v[15:0]), 64'(d));
        end else begin
            eoe = {{46{1'b1}}, 18'd0};
            chk("R3 read header", cap_bit[63:18], f[63:18]);
            chk("R3 read oe", cap_oe, eoe);
            chk("R3 read data", 64'(v[15:0]), 64'(rd));
            chk("R5 read ack", 64'(v[29]), 64'(ack_en));
        end
        chk("R10 mdc low idle", 64'(mdc), 64'd0);
        chk("R10 oe low idle", 64'(mdio_oe), 64'd0);
        bus_read(3'd1, v);
        chk("R8 raw set", 64'(v[0]), 64'd1);
        bus_write(3'd1, 32'd1);
        bus_read(3'd1, v);
        chk("R8 raw cleared by write 1", 64'(v[0]), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_val;
        seed_val = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        bus_read(3'd0, v);
        chk("R1 command reset", 64'(v), 64'd0);
        chk("R1 mdc reset", 64'(mdc), 64'd0);
        chk("R1 oe reset", 64'(mdio_oe), 64'd0);
        chk("R1 irq reset", 64'(irq), 64'd0);

        // directed corners
        run_txn(1'b1, 5'd0,  5'd0,  16'h0000, 1'b1, 16'h0000, 1'b0);
        run_txn(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b1, 16'h0000, 1'b0);
        run_txn(1'b0, 5'd31, 5'd0,  16'h0000, 1'b1, 16'hFFFF, 1'b0);
        run_txn(1'b0, 5'd0,  5'd31, 16'h0000, 1'b1, 16'h0000, 1'b0);
        run_txn(1'b0, 5'd5,  5'd9,  16'h0000, 1'b0, 16'hA5C3, 1'b0);
        run_txn(1'b1, 5'd17, 5'd2,  16'h1234, 1'b1, 16'h0000, 1'b1);
        run_txn(1'b0, 5'd3,  5'd14, 16'h0000, 1'b1, 16'h5A0F, 1'b1);

        // interrupt enable path
        bus_write(3'd3, 32'd1);
        rise_cnt = 0;
        bus_write(3'd0, cmd_word(1'b1, 1'b1, 1'b0, 5'd1, 5'd1, 16'h00FF));
        v = 32'h8000_0000;
        while (v[31]) bus_read(3'd0, v);
        bus_read(3'd4, v);
        chk("R9 masked low when disabled", 64'(v[0]), 64'd0);
        chk("R9 irq low when disabled", 64'(irq), 64'd0);
        bus_write(3'd2, 32'd1);
        bus_read(3'd2, v);
        chk("R9 enable reads back", 64'(v[0]), 64'd1);
        chk("R9 irq high when enabled", 64'(irq), 64'd1);
        bus_read(3'd4, v);
        chk("R9 masked high when enabled", 64'(v[0]), 64'd1);
        bus_write(3'd1, 32'd1);
        chk("R8 irq drops after clear", 64'(irq), 64'd0);
        bus_write(3'd1, 32'd0);
        bus_read(3'd1, v);
        chk("R8 write 0 does not set raw", 64'(v[0]), 64'd0);
        rise_cnt = 0;
        bus_write(3'd0, cmd_word(1'b1, 1'b0, 1'b0, 5'd7, 5'd7, 16'h0000));
        v = 32'h8000_0000;
        while (v[31]) bus_read(3'd0, v);
        chk("R9 irq on read completion", 64'(irq), 64'd1);
        bus_write(3'd3, 32'd1);
        chk("R9 irq off after disable", 64'(irq), 64'd0);
        bus_read(3'd1, v);
        chk("R9 raw kept while disabled", 64'(v[0]), 64'd1);
        bus_write(3'd1, 32'd1);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    ($urandom % 4) != 0, 16'($urandom), ($urandom % 3) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule